// File: doc/BRIEF.md
# Packed Decimal Field Checker

This block validates a packed decimal operand that arrives one byte per accepted transfer, from the most significant byte down to the least significant. Every byte holds two 4-bit decimal digits, except the final byte, which carries one digit in its upper half and the sign code in its lower half. Each byte travels with a ninth bit so that odd parity can be checked. A first flag opens a field and a last flag closes it.

When the closing byte has been accepted, the block reports the verdict in the next cycle: whether the field is well formed, whether its sign is negative, and whether the sign code is the preferred one for the selected character set mode. It also raises separate indications for parity trouble and for a field length outside the legal range. Once any byte of a field fails a check, the failure stays recorded until the field ends, so the verdict covers every byte of the field.

Top module: `pdec_field_check`

## Requirements
- R1: A byte is accepted on a rising clock edge with `in_valid` high. The nine bits `{in_par, in_data}` of every accepted byte must contain an odd number of ones. A byte with even parity makes `res_par_err` 1 and `res_ok` 0 in that field's result.
- R2: Every digit position must hold a value from 0 to 9. The digit positions are both nibbles of a non-last byte and `in_data[7:4]` of the last byte. A value from 10 to 15 in a digit position makes `res_ok` 0.
- R3: The sign is `in_data[3:0]` of the last byte. Codes 11 and 13 decode as minus (`res_neg` = 1). Codes 10, 12, 14 and 15 decode as plus (`res_neg` = 0). A value from 0 to 9 there makes `res_ok` 0, `res_neg` 0 and `res_preferred` 0.
- R4: With `mode_ascii` = 1 (sampled with the last byte), `res_preferred` is 1 only for sign codes 10 and 11. With `mode_ascii` = 0, it is 1 only for codes 12 and 13. Codes 14 and 15 are never preferred.
- R5: A field of 1 to 16 accepted bytes has `res_len_err` = 0. A field of 17 or more bytes has `res_len_err` = 1 and `res_ok` = 0.
- R6: A byte accepted without `in_first` while no field is open starts a field that is reported with `res_len_err` = 1 and `res_ok` = 0.
- R7: `res_valid` is 1 for exactly the one cycle after the last byte is accepted. It is 0 in every other cycle. The result outputs carry that field's verdict in that cycle.
- R8: The result outputs keep their values after the pulse. They are set to 0 in the cycle after a byte is accepted that has `in_first` = 1 and `in_last` = 0.
- R9: An error caused by one byte stays attached to the field even when every later byte is clean. An error from one field never appears in the result of a later field.
- R10: While `in_valid` is 0, `in_data`, `in_par`, `in_first`, `in_last` and `mode_ascii` have no effect: the results are unchanged and `res_valid` stays 0.
- R11: After a synchronous reset, every output is 0 and no field is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte strobe |
| in_first | input | 1 | Byte opens a field |
| in_last | input | 1 | Byte closes a field (holds the sign) |
| in_data | input | 8 | Two nibbles, high nibble more significant |
| in_par | input | 1 | Ninth bit for odd parity |
| mode_ascii | input | 1 | 1 selects ASCII preferred signs, 0 selects EBCDIC |
| res_valid | output | 1 | One-cycle result strobe |
| res_ok | output | 1 | Field passed every check |
| res_neg | output | 1 | Sign decoded as minus |
| res_preferred | output | 1 | Sign code is the preferred one for the mode |
| res_par_err | output | 1 | Some byte of the field had even parity |
| res_len_err | output | 1 | Illegal length or field started without first flag |

## Verification
A wrong internal state shows up only at the next result strobe. A sticky flag that fails to clear taints the verdict of the following field. A flag that fails to hold loses an early error in a long field. A byte counter that is off by one moves the length verdict at the 16/17 boundary. Each of these faults therefore appears at the `res_valid` pulse of the field it affects, one cycle after that field's last byte. The reference model recomputes each verdict from the bytes it drives. It exercises the length boundary, a parity fault on a non-last byte, fields that start without a first flag, and all sixteen sign codes in both modes.

// File: rtl/pdec_pkg.sv
package pdec_pkg;

    localparam int NIB_W = 4;

    typedef enum logic [2:0] {
        SK_NONE,
        SK_PLUS_A,
        SK_MINUS_A,
        SK_PLUS_E,
        SK_MINUS_E,
        SK_PLUS_ANY
    } sign_kind_e;

    typedef struct packed {
        logic par_err;
        logic code_err;
    } byte_flags_t;

    typedef struct packed {
        logic ok;
        logic neg;
        logic pref;
        logic par_err;
        logic len_err;
    } field_result_t;

    function automatic logic nib_is_digit(input logic [NIB_W-1:0] n);
        return n <= NIB_W'(9);
    endfunction

    function automatic sign_kind_e classify_sign(input logic [NIB_W-1:0] n);
        case (n)
            NIB_W'(10): return SK_PLUS_A;
            NIB_W'(11): return SK_MINUS_A;
            NIB_W'(12): return SK_PLUS_E;
            NIB_W'(13): return SK_MINUS_E;
            NIB_W'(14),
            NIB_W'(15): return SK_PLUS_ANY;
            default:    return SK_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pdec_byte_check.sv
module pdec_byte_check
    import pdec_pkg::*;
#(
    parameter int BYTE_W = 8
)(
    input  logic [BYTE_W-1:0] data,
    input  logic              par,
    input  logic              is_last,
    output byte_flags_t       flags
);
    localparam int NIBS = BYTE_W / NIB_W;

    logic [NIBS-1:0] nib_bad;

    for (genvar g = 0; g < NIBS; g++) begin : g_nib
        logic [NIB_W-1:0] nib;
        assign nib = data[g*NIB_W +: NIB_W];
        if (g == 0) begin : g_low
            // low nibble is a digit, or the sign when the byte closes the field
            assign nib_bad[g] = is_last ? nib_is_digit(nib) : !nib_is_digit(nib);
        end else begin : g_high
            assign nib_bad[g] = !nib_is_digit(nib);
        end
    end

    always_comb begin
        flags.par_err  = ~(^{par, data});
        flags.code_err = |nib_bad;
    end
endmodule

// File: rtl/pdec_len_track.sv
module pdec_len_track #(
    parameter int MAX_LEN = 16
)(
    input  logic clk,
    input  logic rst,
    input  logic acc,
    input  logic first,
    input  logic last,
    output logic restart,
    output logic len_bad
);
    localparam int CNT_W = $clog2(MAX_LEN + 2);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(MAX_LEN);

    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    logic             open_q;
    logic             orphan;

    always_comb begin
        restart = first || !open_q;
        orphan  = !first && !open_q;
        if (restart)
            cnt_nxt = CNT_W'(1);
        else if (cnt_q > LIM)
            cnt_nxt = cnt_q;
        else
            cnt_nxt = cnt_q + CNT_W'(1);
        len_bad = orphan || (cnt_nxt > LIM);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            open_q <= 1'b0;
        end else if (acc) begin
            cnt_q  <= cnt_nxt;
            open_q <= !last;
        end
    end
endmodule

// File: rtl/pdec_sign_decode.sv
module pdec_sign_decode
    import pdec_pkg::*;
(
    input  logic [NIB_W-1:0] code,
    input  logic             ascii,
    output logic             sign_ok,
    output logic             neg,
    output logic             pref
);
    sign_kind_e kind;

    always_comb begin
        kind    = classify_sign(code);
        sign_ok = (kind != SK_NONE);
        neg     = (kind == SK_MINUS_A) || (kind == SK_MINUS_E);
        unique case (kind)
            SK_PLUS_A, SK_MINUS_A: pref = ascii;
            SK_PLUS_E, SK_MINUS_E: pref = !ascii;
            default:               pref = 1'b0;
        endcase
    end
endmodule

// File: rtl/pdec_field_check.sv
module pdec_field_check
    import pdec_pkg::*;
#(
    parameter int MAX_LEN = 16,
    parameter int BYTE_W  = 8
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic              in_last,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_par,
    input  logic              mode_ascii,
    output logic              res_valid,
    output logic              res_ok,
    output logic              res_neg,
    output logic              res_preferred,
    output logic              res_par_err,
    output logic              res_len_err
);
    byte_flags_t   bflags;
    logic          restart, len_bad;
    logic          sign_ok, sign_neg, sign_pref;
    logic          par_q, code_q, len_q;
    logic          par_n, code_n, len_n;
    field_result_t res_q, res_n;
    logic          valid_q;

    pdec_byte_check #(.BYTE_W(BYTE_W)) u_byte (
        .data    (in_data),
        .par     (in_par),
        .is_last (in_last),
        .flags   (bflags)
    );

    pdec_len_track #(.MAX_LEN(MAX_LEN)) u_len (
        .clk     (clk),
        .rst     (rst),
        .acc     (in_valid),
        .first   (in_first),
        .last    (in_last),
        .restart (restart),
        .len_bad (len_bad)
    );

    pdec_sign_decode u_sign (
        .code    (in_data[NIB_W-1:0]),
        .ascii   (mode_ascii),
        .sign_ok (sign_ok),
        .neg     (sign_neg),
        .pref    (sign_pref)
    );

    // sticky flags: restart drops the previous field's history
    always_comb begin
        par_n  = (!restart && par_q)  || bflags.par_err;
        code_n = (!restart && code_q) || bflags.code_err;
        len_n  = (!restart && len_q)  || len_bad;

        res_n.par_err = par_n;
        res_n.len_err = len_n;
        res_n.neg     = sign_ok && sign_neg;
        res_n.pref    = sign_ok && sign_pref;
        res_n.ok      = !(par_n || code_n || len_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            par_q   <= 1'b0;
            code_q  <= 1'b0;
            len_q   <= 1'b0;
            res_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= in_valid && in_last;
            if (in_valid) begin
                if (in_last) begin
                    par_q  <= 1'b0;
                    code_q <= 1'b0;
                    len_q  <= 1'b0;
                    res_q  <= res_n;
                end else begin
                    par_q  <= par_n;
                    code_q <= code_n;
                    len_q  <= len_n;
                    if (in_first)
                        res_q <= '0;
                end
            end
        end
    end

    assign res_valid     = valid_q;
    assign res_ok        = res_q.ok;
    assign res_neg       = res_q.neg;
    assign res_preferred = res_q.pref;
    assign res_par_err   = res_q.par_err;
    assign res_len_err   = res_q.len_err;
endmodule

// File: rtl/pdec_field_check_props.sv
module pdec_field_check_props #(
    parameter int BYTE_W = 8
)(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_first,
    input logic              in_last,
    input logic [BYTE_W-1:0] in_data,
    input logic              in_par,
    input logic              mode_ascii,
    input logic              res_valid,
    input logic              res_ok,
    input logic              res_neg,
    input logic              res_preferred,
    input logic              res_par_err,
    input logic              res_len_err
);
    logic [4:0] res_vec;
    assign res_vec = {res_ok, res_neg, res_preferred, res_par_err, res_len_err};

    p_bad_parity_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_last && !(^{in_par, in_data})) |=> (res_valid && res_par_err && !res_ok));

    p_digit_in_sign_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_last && (in_data[3:0] < 4'd10)) |=> (!res_ok && !res_neg && !res_preferred));

    p_minus_code_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_last && (in_data[3:0] == 4'd11 || in_data[3:0] == 4'd13)) |=> res_neg);

    p_ascii_pref_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_last && mode_ascii && (in_data[3:0] >= 4'd12)) |=> !res_preferred);

    p_pulse_source_r7: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(in_valid && in_last));

    p_clear_on_first_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_first && !in_last) |=> (!res_valid && res_vec == 5'd0));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!res_valid && $stable(res_vec)));

    p_ok_clean_r5: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_ok) |-> (!res_par_err && !res_len_err));
endmodule

bind pdec_field_check pdec_field_check_props #(.BYTE_W(BYTE_W)) u_props (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_first      (in_first),
    .in_last       (in_last),
    .in_data       (in_data),
    .in_par        (in_par),
    .mode_ascii    (mode_ascii),
    .res_valid     (res_valid),
    .res_ok        (res_ok),
    .res_neg       (res_neg),
    .res_preferred (res_preferred),
    .res_par_err   (res_par_err),
    .res_len_err   (res_len_err)
);

// File: tb/pdec_field_check_test.sv
module pdec_field_check_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_par = 1'b0, mode_ascii = 1'b0;
    logic       res_valid, res_ok, res_neg, res_preferred, res_par_err, res_len_err;

    always #4 clk = ~clk;  // 125 MHz

    pdec_field_check uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
        .in_last(in_last), .in_data(in_data), .in_par(in_par),
        .mode_ascii(mode_ascii), .res_valid(res_valid), .res_ok(res_ok),
        .res_neg(res_neg), .res_preferred(res_preferred),
        .res_par_err(res_par_err), .res_len_err(res_len_err)
    );

    typedef struct packed {
        logic ok;
        logic neg;
        logic pref;
        logic par;
        logic len;
        logic orphan;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 0;

    logic [7:0] fd [0:31];
    logic       fp [0:31];

    task automatic chk(input bit cond, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // monitor: compares each result strobe with the queued expectation
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R7", "unexpected result strobe", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(res_par_err == e.par, "R1", "res_par_err", res_par_err, e.par);
                chk(res_ok == e.ok, "R2", "res_ok", res_ok, e.ok);
                chk(res_neg == e.neg, "R3", "res_neg", res_neg, e.neg);
                chk(res_preferred == e.pref, "R4", "res_preferred", res_preferred, e.pref);
                chk(res_len_err == e.len, e.orphan ? "R6" : "R5", "res_len_err", res_len_err, e.len);
            end
        end
    end

    function automatic logic odd_par(input logic [7:0] d);
        return ~(^d);
    endfunction

    // reference model for one field held in fd/fp
    function automatic exp_t model(input int n, input bit mode, input bit orphan);
        exp_t e;
        logic code;
        logic [3:0] s;
        e = '0;
        code = 0;
        for (int i = 0; i < n; i++) begin
            if (^{fp[i], fd[i]} == 1'b0) e.par = 1;
            if (fd[i][7:4] > 4'd9) code = 1;
            if (i != n-1 && fd[i][3:0] > 4'd9) code = 1;
        end
        s = fd[n-1][3:0];
        if (s < 4'd10) code = 1;
        e.neg    = (s == 4'd11) || (s == 4'd13);
        e.pref   = mode ? (s == 4'd10 || s == 4'd11) : (s == 4'd12 || s == 4'd13);
        e.len    = orphan || (n > 16);
        e.orphan = orphan;
        e.ok     = !(e.par || code || e.len);
        return e;
    endfunction

    task automatic idle(input int cycles);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            in_valid   = 1'b0;
            in_data    = 8'($urandom);
            in_par     = 1'($urandom);
            in_first   = 1'($urandom);
            in_last    = 1'($urandom);
            mode_ascii = 1'($urandom);
        end
    endtask

    task automatic send_field(input int n, input bit mode, input bit orphan, input int gap_max);
        exp_q.push_back(model(n, mode, orphan));
        for (int i = 0; i < n; i++) begin
            if (gap_max > 0) idle($urandom_range(gap_max, 0));
            @(negedge clk);
            in_valid   = 1'b1;
            in_data    = fd[i];
            in_par     = fp[i];
            in_first   = (i == 0) && !orphan;
            in_last    = (i == n-1);
            mode_ascii = (i == n-1) ? mode : 1'($urandom);
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(res_valid == 1'b1, "R7", "res_valid after last byte", res_valid, 1);
    endtask

    task automatic fill_clean(input int n, input logic [3:0] sign);
        for (int i = 0; i < n; i++) begin
            fd[i][7:4] = 4'($urandom_range(9, 0));
            fd[i][3:0] = (i == n-1) ? sign : 4'($urandom_range(9, 0));
            fp[i]      = odd_par(fd[i]);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        logic [5:0] held;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk({res_valid, res_ok, res_neg, res_preferred, res_par_err, res_len_err} == 6'd0,
            "R11", "outputs during reset", 0, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({res_valid, res_ok, res_neg, res_preferred, res_par_err, res_len_err} == 6'd0,
            "R11", "outputs after reset", 0, 0);

        // R3 R4: every sign code in both modes
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 16; s++) begin
                fill_clean(3, 4'(s));
                send_field(3, m[0], 0, 0);
            end

        // R5: boundary lengths 1, 16, 17
        fill_clean(1, 4'd12);  send_field(1, 0, 0, 1);
        fill_clean(16, 4'd13); send_field(16, 0, 0, 1);
        fill_clean(17, 4'd12); send_field(17, 0, 0, 0);
        fill_clean(20, 4'd10); send_field(20, 1, 0, 0);

        // R2: bad digit in upper and lower nibble of a middle byte
        fill_clean(4, 4'd12); fd[1][7:4] = 4'd10; fp[1] = odd_par(fd[1]); send_field(4, 0, 0, 0);
        fill_clean(4, 4'd12); fd[2][3:0] = 4'd15; fp[2] = odd_par(fd[2]); send_field(4, 0, 0, 0);
        fill_clean(4, 4'd12); fd[3][7:4] = 4'd14; fp[3] = odd_par(fd[3]); send_field(4, 0, 0, 0);

        // R9: parity fault on the first byte of a long field stays
        fill_clean(8, 4'd13); fp[0] = ~fp[0];
        send_field(8, 0, 0, 2);
        chk(res_par_err == 1'b1, "R9", "sticky parity error", res_par_err, 1);
        fill_clean(8, 4'd13);
        send_field(8, 0, 0, 0);
        chk(res_par_err == 1'b0, "R9", "error cleared in next field", res_par_err, 0);

        // R6: field without first flag while nothing is open
        fill_clean(3, 4'd12); send_field(3, 0, 1, 0);
        fill_clean(1, 4'd12); send_field(1, 0, 1, 0);

        // R10: idle cycles with random inputs change nothing
        fill_clean(2, 4'd11); send_field(2, 1, 0, 0);
        held = {res_ok, res_neg, res_preferred, res_par_err, res_len_err, 1'b0};
        idle(10);
        @(negedge clk);
        chk({res_ok, res_neg, res_preferred, res_par_err, res_len_err, res_valid} == held,
            "R10", "results across idle cycles", 32'({res_ok, res_neg, res_preferred, res_par_err, res_len_err, res_valid}), 32'(held));

        // R8: a first non-last byte clears the results
        fill_clean(3, 4'd11);
        exp_q.push_back(model(3, 1, 0));
        @(negedge clk);
        in_valid = 1'b1; in_first = 1'b1; in_last = 1'b0; in_data = fd[0]; in_par = fp[0];
        @(negedge clk);
        in_valid = 1'b0;
        chk({res_valid, res_ok, res_neg, res_preferred, res_par_err, res_len_err} == 6'd0,
            "R8", "results cleared by first byte", 32'({res_valid, res_ok, res_neg, res_preferred, res_par_err, res_len_err}), 0);
        for (int i = 1; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_first = 1'b0; in_last = (i == 2);
            in_data = fd[i]; in_par = fp[i]; mode_ascii = 1'b1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(res_valid == 1'b1, "R7", "res_valid after last byte", res_valid, 1);
        @(negedge clk);
        chk(res_valid == 1'b0, "R7", "res_valid is a single pulse", res_valid, 0);

        // random fields against the reference model
        for (int f = 0; f < 300; f++) begin
            int n;
            n = $urandom_range(20, 1);
            fill_clean(n, 4'($urandom_range(15, 10)));
            if ($urandom_range(7, 0) == 0) begin
                int b;
                b = $urandom_range(n-1, 0);
                fd[b] = 8'($urandom);
                fp[b] = odd_par(fd[b]);
            end
            if ($urandom_range(9, 0) == 0) begin
                int b;
                b = $urandom_range(n-1, 0);
                fp[b] = ~fp[b];
            end
            send_field(n, 1'($urandom), ($urandom_range(19, 0) == 0), 2);
        end

        idle(3);
        chk(exp_q.size() == 0, "R7", "results still pending", exp_q.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule